// File: doc/BRIEF.md
# Data-cache maintenance command controller

This controller sequences maintenance commands for a data cache. A command names an operation (invalidate, write-back, or write-back followed by invalidate) and covers either the whole cache or a byte range given as a start address and a length. The controller turns each command into writes on the cache's control path: a whole-cache strobe, or one write per line to the per-line flush or invalidate register. When split tag/index mode is built in, each per-line write comes after a write of the same line address to the physical-tag register.

The cache has no native write-back-and-invalidate command. The controller builds one by switching the invalidate sub-mode from discard to flush-before-invalidate, issuing invalidates, waiting for the flush-busy status to drop, and then restoring discard mode. A separate disable request performs a whole-cache write-back, waits for it to finish, and then sets the cache-off bit. The controller holds one command at a time and pulses `done` for one cycle after its final step.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: Operation code bit 0 selects the invalidate registers and bit 1 marks a write-back. Code 1 writes only invalidate registers, code 2 writes only flush registers, and code 3 writes only invalidate registers. Code 0 makes no write and still completes with `done`.
- R2: A range command writes line addresses that start at the start address rounded down to LINE_BYTES and rise by LINE_BYTES. The number of writes is ceil((length + start mod LINE_BYTES) / LINE_BYTES).
- R3: With SPLIT_TAG=1, every per-line write is preceded in the previous cycle by a physical-tag write carrying the same address. With SPLIT_TAG=0, no physical-tag write occurs.
- R4: A whole-cache command makes exactly one whole-cache write (flush or invalidate, chosen as in R1), and that write carries the data value 1.
- R5: For code 3, the invalidate-mode bit is high during every invalidate write. It stays high until flush-busy has been sampled low. For codes 1 and 2 it is low during every write.
- R6: A command with bit 1 set does not raise `done` while a write-back it started keeps flush-busy high.
- R7: A pure invalidate (code 1) finishes without waiting, even when flush-busy is held high throughout.
- R8: After reset the invalidate-mode bit, `cache_off`, `done` and all write strobes are low and `cmd_ready` is high. The mode bit is low whenever `done` is high.
- R9: A range command with length 0 makes no write and never raises the invalidate-mode bit.
- R10: `cmd_ready` is low from acceptance until `done`. A command presented while not ready is ignored.
- R11: `done` is high for exactly one cycle per command.
- R12: A disable request makes one whole-cache flush write, waits for flush-busy to be low, and only then sets `cache_off`, followed by `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command accepted this cycle |
| cmd_op | input | 2 | Operation code (1 inv, 2 write-back, 3 both) |
| cmd_whole | input | 1 | 1 = whole cache, 0 = range |
| cmd_addr | input | ADDR_W | Range start address |
| cmd_len | input | LEN_W | Range length in bytes |
| off_req | input | 1 | Disable request, taken when idle, has priority over cmd_valid |
| flush_busy | input | 1 | Write-back in progress status from the cache |
| inv_mode_flush | output | 1 | Invalidate sub-mode: 1 flush-before-invalidate, 0 discard |
| all_flush_we | output | 1 | Whole-cache flush register write |
| all_inv_we | output | 1 | Whole-cache invalidate register write |
| line_flush_we | output | 1 | Per-line flush register write |
| line_inv_we | output | 1 | Per-line invalidate register write |
| ptag_we | output | 1 | Physical-tag register write |
| maint_wdata | output | ADDR_W | Write data: line address, or 1 for whole-cache writes |
| cache_off | output | 1 | Cache disable bit |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the controller with 16-byte lines, 16-bit addresses and 8-bit lengths. At that size every start offset within a line, combined with every length from 0 to 40, can be swept for all three operations, which reaches the zero-length, single-line and line-straddling cases. A second instance built without split tag mode runs the same commands. It confirms the plain per-line sequence and that no physical-tag write occurs. A flush-busy model that rises after each write-back strobe exercises the wait. Holding flush-busy high during pure invalidates shows that they do not wait.

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 32,
  parameter bit SPLIT_TAG  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_whole,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              off_req,
  input  logic              flush_busy,
  output logic              inv_mode_flush,
  output logic              all_flush_we,
  output logic              all_inv_we,
  output logic              line_flush_we,
  output logic              line_inv_we,
  output logic              ptag_we,
  output logic [ADDR_W-1:0] maint_wdata,
  output logic              cache_off,
  output logic              done
);

  localparam int OFS   = $clog2(LINE_BYTES);
  localparam int SUM_W = LEN_W + 2;
  localparam int CNT_W = SUM_W - OFS;

  typedef enum logic [3:0] {
    S_IDLE, S_MODE, S_TAG, S_LINE, S_WHOLE, S_WAIT, S_RESTORE, S_OFF, S_DONE
  } state_t;

  state_t            st;
  logic [1:0]        op;
  logic              whole, dis;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  left;

  logic [SUM_W-1:0]  span;
  state_t            line_first, after_issue;

  assign span = SUM_W'(cmd_len) + SUM_W'(cmd_addr[OFS-1:0]) + SUM_W'(LINE_BYTES - 1);
  assign line_first  = SPLIT_TAG ? S_TAG : S_LINE;
  assign after_issue = op[1] ? S_WAIT : S_DONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      op             <= 2'd0;
      whole          <= 1'b0;
      dis            <= 1'b0;
      addr           <= '0;
      left           <= '0;
      inv_mode_flush <= 1'b0;
      cache_off      <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (off_req) begin
            op    <= 2'd2;
            whole <= 1'b1;
            dis   <= 1'b1;
            st    <= S_WHOLE;
          end else if (cmd_valid) begin
            op    <= cmd_op;
            whole <= cmd_whole;
            dis   <= 1'b0;
            addr  <= {cmd_addr[ADDR_W-1:OFS], {OFS{1'b0}}};
            left  <= span[SUM_W-1:OFS];
            if (cmd_op == 2'd0 || (!cmd_whole && cmd_len == '0))
              st <= S_DONE;
            else if (cmd_op == 2'd3)
              st <= S_MODE;
            else
              st <= cmd_whole ? S_WHOLE : line_first;
          end
        end
        S_MODE: begin
          inv_mode_flush <= 1'b1;
          st <= whole ? S_WHOLE : line_first;
        end
        S_TAG:   st <= S_LINE;
        S_LINE: begin
          addr <= addr + ADDR_W'(LINE_BYTES);
          left <= left - 1'b1;
          st   <= (left == CNT_W'(1)) ? after_issue : line_first;
        end
        S_WHOLE: st <= after_issue;
        S_WAIT: begin
          if (!flush_busy)
            st <= dis ? S_OFF : ((op == 2'd3) ? S_RESTORE : S_DONE);
        end
        S_RESTORE: begin
          inv_mode_flush <= 1'b0;
          st <= S_DONE;
        end
        S_OFF: begin
          cache_off <= 1'b1;
          st <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (st == S_IDLE);
  assign done          = (st == S_DONE);
  assign ptag_we       = (st == S_TAG);
  assign line_inv_we   = (st == S_LINE) &&  op[0];
  assign line_flush_we = (st == S_LINE) && !op[0];
  assign all_inv_we    = (st == S_WHOLE) &&  op[0];
  assign all_flush_we  = (st == S_WHOLE) && !op[0];
  assign maint_wdata   = (st == S_WHOLE) ? ADDR_W'(1) : addr;

endmodule

// File: rtl/dcache_maint_ctrl_chk.sv
module dcache_maint_ctrl_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter bit SPLIT_TAG  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              flush_busy,
  input logic              inv_mode_flush,
  input logic              all_flush_we,
  input logic              all_inv_we,
  input logic              line_flush_we,
  input logic              line_inv_we,
  input logic              ptag_we,
  input logic [ADDR_W-1:0] maint_wdata,
  input logic              cache_off,
  input logic              done
);
  localparam int OFS = $clog2(LINE_BYTES);

  p_one_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({all_flush_we, all_inv_we, line_flush_we, line_inv_we, ptag_we}));

  p_line_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_flush_we || line_inv_we) |-> (maint_wdata[OFS-1:0] == '0));

  p_tag_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (SPLIT_TAG && (line_flush_we || line_inv_we)) |->
      ($past(ptag_we) && $past(maint_wdata) == maint_wdata));

  p_no_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !SPLIT_TAG |-> !ptag_we);

  p_whole_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (all_flush_we || all_inv_we) |-> (maint_wdata == ADDR_W'(1)));

  p_mode_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inv_mode_flush) |-> $past(!flush_busy, 2));

  p_mode_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !inv_mode_flush);

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_flush_we || line_inv_we || all_flush_we || all_inv_we || ptag_we) |-> !cmd_ready);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));

  p_off_after_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cache_off) |-> $past(!flush_busy, 2));
endmodule

bind dcache_maint_ctrl dcache_maint_ctrl_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SPLIT_TAG(SPLIT_TAG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .flush_busy(flush_busy),
  .inv_mode_flush(inv_mode_flush), .all_flush_we(all_flush_we), .all_inv_we(all_inv_we),
  .line_flush_we(line_flush_we), .line_inv_we(line_inv_we), .ptag_we(ptag_we),
  .maint_wdata(maint_wdata), .cache_off(cache_off), .done(done)
);

// File: tb/dcache_maint_ctrl_test.sv
module dcache_maint_ctrl_test;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int LB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_whole = 1'b0, off_req = 1'b0, flush_busy = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;

  logic rdy, mode, afl, ainv, lfl, linv, ptag, coff, dn;
  logic [AW-1:0] wd;
  logic rdy2, mode2, afl2, ainv2, lfl2, linv2, ptag2, coff2, dn2;
  logic [AW-1:0] wd2;

  always #4 clk = ~clk;

  dcache_maint_ctrl #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB), .SPLIT_TAG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy), .cmd_op(cmd_op),
    .cmd_whole(cmd_whole), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .off_req(off_req),
    .flush_busy(flush_busy), .inv_mode_flush(mode), .all_flush_we(afl), .all_inv_we(ainv),
    .line_flush_we(lfl), .line_inv_we(linv), .ptag_we(ptag), .maint_wdata(wd),
    .cache_off(coff), .done(dn));

  dcache_maint_ctrl #(.ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB), .SPLIT_TAG(1'b0)) uut_nt (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy2), .cmd_op(cmd_op),
    .cmd_whole(cmd_whole), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .off_req(off_req),
    .flush_busy(flush_busy), .inv_mode_flush(mode2), .all_flush_we(afl2), .all_inv_we(ainv2),
    .line_flush_we(lfl2), .line_inv_we(linv2), .ptag_we(ptag2), .maint_wdata(wd2),
    .cache_off(coff2), .done(dn2));

  int checks = 0, errors = 0;
  int bcnt = 0;
  bit force_busy = 1'b0;

  int lines, tags, wholes, nt_lines, nt_tags, exp_addr, nt_addr;
  int kind_err, addr_err, tag_err, mode_err, busy_err, pulse_err, wdata_err, zero_mode_err;
  bit d1, d2, prev_done, prev_mode, tag_ok;
  int last_tag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sample(input logic [1:0] op, input bit whole, input int len);
    if (ptag) begin tags++; last_tag = int'(wd); tag_ok = 1'b1; end
    if (lfl || linv) begin
      if (linv != op[0]) kind_err++;
      if (int'(wd) != exp_addr) addr_err++;
      if (!tag_ok || last_tag != int'(wd)) tag_err++;
      tag_ok = 1'b0;
      if (linv && mode != (op == 2'd3)) mode_err++;
      if (lfl && mode) mode_err++;
      exp_addr = (exp_addr + LB) & 16'hffff;
      lines++;
    end
    if (afl || ainv) begin
      wholes++;
      if (ainv != op[0]) kind_err++;
      if (wd != 16'd1) wdata_err++;
      if (ainv && mode != (op == 2'd3)) mode_err++;
    end
    if (prev_mode && !mode && bcnt > 0) mode_err++;
    if (!whole && len == 0 && mode) zero_mode_err++;
    if (dn) begin
      d1 = 1'b1;
      if (op[1] && bcnt > 0) busy_err++;
      if (mode) mode_err++;
    end
    if (prev_done && dn) pulse_err++;
    prev_done = dn;
    prev_mode = mode;
    if (ptag2) nt_tags++;
    if (lfl2 || linv2) begin
      if (int'(wd2) != nt_addr) addr_err++;
      nt_addr = (nt_addr + LB) & 16'hffff;
      nt_lines++;
    end
    if (dn2) d2 = 1'b1;
    if (afl || lfl || (ainv && mode) || (linv && mode)) bcnt = 4;
    else if (bcnt > 0) bcnt--;
    flush_busy = force_busy || (bcnt > 0);
  endtask

  task automatic run_cmd(input logic [1:0] op, input bit whole, input int a, input int len,
                         input bit dis, input bit inject);
    int exp_n;
    int cyc;
    exp_n = (len == 0) ? 0 : ((a % LB) + len + LB - 1) / LB;
    lines = 0; tags = 0; wholes = 0; nt_lines = 0; nt_tags = 0;
    kind_err = 0; addr_err = 0; tag_err = 0; mode_err = 0; busy_err = 0;
    pulse_err = 0; wdata_err = 0; zero_mode_err = 0;
    d1 = 1'b0; d2 = 1'b0; prev_done = 1'b0; prev_mode = 1'b0; tag_ok = 1'b0;
    exp_addr = a & ~(LB - 1); nt_addr = exp_addr;
    @(negedge clk);
    cmd_op = dis ? 2'd2 : op; cmd_whole = whole; cmd_addr = AW'(a); cmd_len = LW'(len);
    cmd_valid = !dis; off_req = dis;
    force_busy = (op == 2'd1) && !dis;
    flush_busy = force_busy;
    @(negedge clk);
    cmd_valid = 1'b0; off_req = 1'b0;
    chk(!rdy, "R10", rdy, 0);
    cyc = 0;
    while (cyc < 400 && !(d1 && d2)) begin
      sample(dis ? 2'd2 : op, whole || dis, len);
      if (inject && cyc == 1) begin
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_whole = 1'b1;
      end
      if (inject && cyc == 2) cmd_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    sample(dis ? 2'd2 : op, whole || dis, len);
    force_busy = 1'b0;
    flush_busy = bcnt > 0;
    chk(d1 && d2, "R11", int'(d1), 1);
    chk(pulse_err == 0, "R11", pulse_err, 0);
    chk(kind_err == 0, "R1", kind_err, 0);
    chk(mode_err == 0, "R5", mode_err, 0);
    chk(busy_err == 0, "R6", busy_err, 0);
    if (dis) begin
      chk(wholes == 1 && lines == 0, "R12", wholes, 1);
      chk(coff == 1'b1 && coff2 == 1'b1, "R12", coff, 1);
    end else if (op == 2'd0) begin
      chk(wholes + lines + tags == 0, "R1", wholes + lines + tags, 0);
    end else if (whole) begin
      chk(wholes == 1 && lines == 0 && tags == 0, "R4", wholes, 1);
      chk(wdata_err == 0, "R4", wdata_err, 0);
    end else begin
      chk(lines == exp_n && wholes == 0, "R2", lines, exp_n);
      chk(addr_err == 0, "R2", addr_err, 0);
      chk(tag_err == 0 && tags == exp_n, "R3", tags, exp_n);
      chk(nt_tags == 0 && nt_lines == exp_n, "R3", nt_lines, exp_n);
      if (len == 0) chk(zero_mode_err == 0 && lines == 0, "R9", zero_mode_err, 0);
      if (op == 2'd1) chk(d1, "R7", int'(d1), 1);
      if (inject) chk(lines == exp_n && wholes == 0, "R10", wholes, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(rdy && !mode && !coff && !dn && !(afl | ainv | lfl | linv | ptag), "R8", int'(rdy), 1);
    for (int op = 0; op < 4; op++)
      for (int off = 0; off < LB; off++)
        for (int len = 0; len <= 40; len++)
          run_cmd(2'(op), 1'b0, 16'h1230 + off + op * 16'h0400, len, 1'b0, 1'b0);
    for (int op = 0; op < 4; op++) run_cmd(2'(op), 1'b1, 16'h0, 0, 1'b0, 1'b0);
    run_cmd(2'd2, 1'b0, 16'h2005, 100, 1'b0, 1'b1);
    run_cmd(2'd3, 1'b0, 16'hfffa, 20, 1'b0, 1'b0);
    chk(!coff, "R12", coff, 0);
    run_cmd(2'd0, 1'b1, 16'h0, 0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    chk(!dn && rdy && !mode, "R8", int'(mode), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule